// File: doc/BRIEF.md
# L2 Forwarding Lookup Engine

This engine finds the unicast forwarding entry for a destination MAC address and VLAN ID. The caller supplies the MAC, the VID and an 11-bit bucket key that was computed elsewhere, then pulses a start strobe. The engine first reads the four slots of that bucket from the hashed forwarding SRAM. If no slot matches, it reads the 64-entry overflow CAM. It issues one memory read per cycle and checks the data of the previous read in the same cycle.

Each stored row is 96 bits wide, made of three 32-bit words. Word 0 is in bits 31:0, word 1 in bits 63:32 and word 2 in bits 95:64. A row has no dedicated valid bit, so the engine infers occupancy from a group of flag bits. Rows that describe IP multicast groups or Ethernet group addresses are never treated as unicast matches. The engine returns hit or miss, which memory produced the hit, the slot or CAM index, and the egress port held in the row. When it finishes, it pulses a single-cycle done.

Top module: `l2_fwd_lookup`

## Requirements
- R1: While reset is asserted and after it is released, done_o, hit_o, sram_rd_en_o and cam_rd_en_o are low until a start is accepted.
- R2: A scan reads SRAM address {bucket, slot} for slots 0, 1, 2 and 3, then CAM addresses 0 to 63, one read per cycle. Each read returns data one cycle after its enable. A hit at scan position k (slots are positions 0 to 3, CAM entry c is position 4+c) raises done k+2 cycles after the clock edge that sampled start. A miss raises done 69 cycles after that edge.
- R3: The row's MAC is {word1[27:0], word2[31:12]} and its VID is word0[11:0]. A row matches only if both equal the request.
- R4: A row is occupied when any of word0 bits 22:18 is set, or when any of word1 bits 31, 30 or 28 is set. A row with none of these bits set is skipped, even if only word0 bit 17 or word1 bit 29 is set.
- R5: A row with word0 bit 22 (IPv4 group) or word0 bit 21 (IPv6 group) set never matches.
- R6: A row whose stored MAC has bit 40 set (the group bit of the first octet) never matches.
- R7: The first matching position in scan order wins. Any matching bucket slot wins over any CAM entry.
- R8: On a hit, hit_o is 1. hit_in_cam_o is 0 for a slot and 1 for a CAM entry. hit_idx_o is the slot number (0 to 3) or the CAM index (0 to 63). hit_port_o is word0[16:12] of the matching row.
- R9: On a miss, hit_o, hit_in_cam_o, hit_idx_o and hit_port_o are all zero.
- R10: done_o is high for exactly one cycle. The result outputs keep their value until the next done.
- R11: A start pulse during a scan is ignored. The running scan finishes with the request captured at its own start and with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a lookup; sampled only when idle |
| mac_i | input | 48 | Destination MAC to look up |
| vid_i | input | 12 | VLAN ID to look up |
| bucket_i | input | 11 | Hash bucket key |
| done_o | output | 1 | One-cycle completion strobe |
| hit_o | output | 1 | A matching entry was found |
| hit_in_cam_o | output | 1 | The hit came from the CAM |
| hit_idx_o | output | 6 | Slot number or CAM index of the hit |
| hit_port_o | output | 5 | Egress port of the hit |
| sram_rd_en_o | output | 1 | Read enable for the bucket SRAM |
| sram_rd_addr_o | output | 13 | SRAM address {bucket, slot} |
| sram_rd_data_i | input | 96 | SRAM row, one cycle after the enable |
| cam_rd_en_o | output | 1 | Read enable for the CAM |
| cam_rd_addr_o | output | 6 | CAM entry address |
| cam_rd_data_i | input | 96 | CAM row, one cycle after the enable |

## Verification
The assertions take two things for granted. Both memories return a row exactly one cycle after each enable. Their contents do not change while a scan is running. Under these conditions, the read ordering, the single-cycle done and the zeroed miss result follow from the engine alone. The bench memory models register their output on the enable edge. The bench rewrites rows only between lookups. The SRAM model returns zeros for any address outside the bucket under test, so a wrong bucket field shows up as a miss.

// File: rtl/l2_lookup_pkg.sv
package l2_lookup_pkg;

    localparam int ENTRY_W = 96;
    localparam int WORD_W  = 32;
    localparam int MAC_W   = 48;
    localparam int VID_W   = 12;
    localparam int PORT_W  = 5;

    // Bit positions inside the stored row that the decoder relies on
    localparam int W0_IP4_GRP    = 22;
    localparam int W0_IP6_GRP    = 21;
    localparam int W0_FLAG_HI    = 22;
    localparam int W0_FLAG_LO    = 18;
    localparam int W0_PORT_LO    = 12;
    localparam int W1_MAC_BITS   = 28;
    localparam int W1_BLK_SRC    = 31;
    localparam int W1_BLK_DST    = 30;
    localparam int W1_NEXT_HOP   = 28;
    localparam int W2_MAC_LO     = 12;
    localparam int MAC_GROUP_BIT = 40;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic [MAC_W-1:0]  mac;
        logic [VID_W-1:0]  vid;
        logic [PORT_W-1:0] port;
        logic              ip_group;
        logic              eth_group;
        logic              occupied;
    } row_fields_t;

endpackage

// File: rtl/l2_entry_decode.sv
module l2_entry_decode
    import l2_lookup_pkg::*;
(
    input  logic [ENTRY_W-1:0] row_i,
    input  logic [MAC_W-1:0]   req_mac_i,
    input  logic [VID_W-1:0]   req_vid_i,
    output logic               match_o,
    output logic [PORT_W-1:0]  port_o
);

    logic [WORD_W-1:0] w0;
    logic [WORD_W-1:0] w1;
    logic [WORD_W-1:0] w2;
    row_fields_t       f;

    always_comb begin
        w0 = row_i[WORD_W-1:0];
        w1 = row_i[2*WORD_W-1:WORD_W];
        w2 = row_i[3*WORD_W-1:2*WORD_W];

        f.mac       = {w1[W1_MAC_BITS-1:0], w2[WORD_W-1:W2_MAC_LO]};
        f.vid       = w0[VID_W-1:0];
        f.port      = w0[W0_PORT_LO +: PORT_W];
        f.ip_group  = w0[W0_IP4_GRP] | w0[W0_IP6_GRP];
        f.eth_group = f.mac[MAC_GROUP_BIT];
        // No valid bit: a row counts as occupied if any flag of the group is set
        f.occupied  = (|w0[W0_FLAG_HI:W0_FLAG_LO])
                    | w1[W1_BLK_SRC] | w1[W1_BLK_DST] | w1[W1_NEXT_HOP];

        match_o = f.occupied && !f.ip_group && !f.eth_group
               && (f.mac == req_mac_i) && (f.vid == req_vid_i);
        port_o  = f.port;
    end

endmodule

// File: rtl/l2_scan_ctrl.sv
module l2_scan_ctrl
    import l2_lookup_pkg::*;
#(
    parameter int BUCKET_W  = 11,
    parameter int SLOTS     = 4,
    parameter int CAM_DEPTH = 64,
    parameter int SLOT_W    = $clog2(SLOTS),
    parameter int CAM_W     = $clog2(CAM_DEPTH),
    parameter int IDX_W     = (CAM_W > SLOT_W) ? CAM_W : SLOT_W
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic [MAC_W-1:0]           mac_i,
    input  logic [VID_W-1:0]           vid_i,
    input  logic [BUCKET_W-1:0]        bucket_i,
    output logic [MAC_W-1:0]           req_mac_o,
    output logic [VID_W-1:0]           req_vid_o,
    input  logic [1:0]                 match_i,
    input  logic [1:0][PORT_W-1:0]     port_i,
    output logic                       sram_rd_en_o,
    output logic [BUCKET_W+SLOT_W-1:0] sram_rd_addr_o,
    output logic                       cam_rd_en_o,
    output logic [CAM_W-1:0]           cam_rd_addr_o,
    output logic                       done_o,
    output logic                       hit_o,
    output logic                       in_cam_o,
    output logic [IDX_W-1:0]           idx_o,
    output logic [PORT_W-1:0]          port_o
);

    localparam int TOTAL = SLOTS + CAM_DEPTH;
    localparam int POS_W = $clog2(TOTAL + 1);

    typedef struct packed {
        scan_state_e         st;
        logic [POS_W-1:0]    pos;
        logic                chk_vld;
        logic [POS_W-1:0]    chk_pos;
        logic [BUCKET_W-1:0] bucket;
        logic [MAC_W-1:0]    mac;
        logic [VID_W-1:0]    vid;
        logic                done;
        logic                hit;
        logic                in_cam;
        logic [IDX_W-1:0]    idx;
        logic [PORT_W-1:0]   port;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              chk_cam;
    logic              sel_match;
    logic [PORT_W-1:0] sel_port;
    logic              finish;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.done     = 1'b0;
        sram_rd_en_o   = 1'b0;
        cam_rd_en_o    = 1'b0;
        sram_rd_addr_o = {ctl_q.bucket, ctl_q.pos[SLOT_W-1:0]};
        cam_rd_addr_o  = CAM_W'(ctl_q.pos - POS_W'(SLOTS));
        chk_cam        = (ctl_q.chk_pos >= POS_W'(SLOTS));
        sel_match      = chk_cam ? match_i[1] : match_i[0];
        sel_port       = chk_cam ? port_i[1]  : port_i[0];
        finish         = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st      = ST_SCAN;
                    ctl_d.pos     = '0;
                    ctl_d.chk_vld = 1'b0;
                    ctl_d.bucket  = bucket_i;
                    ctl_d.mac     = mac_i;
                    ctl_d.vid     = vid_i;
                end
            end
            ST_SCAN: begin
                // Check the row returned for the read issued last cycle
                if (ctl_q.chk_vld) begin
                    if (sel_match) begin
                        finish       = 1'b1;
                        ctl_d.hit    = 1'b1;
                        ctl_d.in_cam = chk_cam;
                        ctl_d.idx    = chk_cam ? IDX_W'(ctl_q.chk_pos - POS_W'(SLOTS))
                                               : IDX_W'(ctl_q.chk_pos);
                        ctl_d.port   = sel_port;
                    end else if (ctl_q.chk_pos == POS_W'(TOTAL - 1)) begin
                        finish       = 1'b1;
                        ctl_d.hit    = 1'b0;
                        ctl_d.in_cam = 1'b0;
                        ctl_d.idx    = '0;
                        ctl_d.port   = '0;
                    end
                end

                if (finish) begin
                    ctl_d.st      = ST_IDLE;
                    ctl_d.done    = 1'b1;
                    ctl_d.chk_vld = 1'b0;
                end else if (ctl_q.pos < POS_W'(TOTAL)) begin
                    // Issue the next read, slots first, then the CAM
                    if (ctl_q.pos < POS_W'(SLOTS)) begin
                        sram_rd_en_o = 1'b1;
                    end else begin
                        cam_rd_en_o  = 1'b1;
                    end
                    ctl_d.chk_vld = 1'b1;
                    ctl_d.chk_pos = ctl_q.pos;
                    ctl_d.pos     = ctl_q.pos + 1'b1;
                end else begin
                    ctl_d.chk_vld = 1'b0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_mac_o = ctl_q.mac;
    assign req_vid_o = ctl_q.vid;
    assign done_o    = ctl_q.done;
    assign hit_o     = ctl_q.hit;
    assign in_cam_o  = ctl_q.in_cam;
    assign idx_o     = ctl_q.idx;
    assign port_o    = ctl_q.port;

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R10

    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(hit_o) && $stable(idx_o) && $stable(port_o) && $stable(in_cam_o))); // R10

    AST_MISS_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !hit_o) |-> (idx_o == '0 && port_o == '0 && !in_cam_o)); // R9

    AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sram_rd_en_o && cam_rd_en_o)); // R2

    AST_CAM_AFTER_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cam_rd_en_o) |-> $past(sram_rd_en_o)); // R7

    AST_SLOT_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && hit_o && !in_cam_o) |-> (idx_o < IDX_W'(SLOTS))); // R8

endmodule

// File: rtl/l2_fwd_lookup.sv
module l2_fwd_lookup
    import l2_lookup_pkg::*;
#(
    parameter int BUCKET_W  = 11,
    parameter int SLOTS     = 4,
    parameter int CAM_DEPTH = 64,
    parameter int SLOT_W    = $clog2(SLOTS),
    parameter int CAM_W     = $clog2(CAM_DEPTH),
    parameter int IDX_W     = (CAM_W > SLOT_W) ? CAM_W : SLOT_W
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic [MAC_W-1:0]           mac_i,
    input  logic [VID_W-1:0]           vid_i,
    input  logic [BUCKET_W-1:0]        bucket_i,
    output logic                       done_o,
    output logic                       hit_o,
    output logic                       hit_in_cam_o,
    output logic [IDX_W-1:0]           hit_idx_o,
    output logic [PORT_W-1:0]          hit_port_o,
    output logic                       sram_rd_en_o,
    output logic [BUCKET_W+SLOT_W-1:0] sram_rd_addr_o,
    input  logic [ENTRY_W-1:0]         sram_rd_data_i,
    output logic                       cam_rd_en_o,
    output logic [CAM_W-1:0]           cam_rd_addr_o,
    input  logic [ENTRY_W-1:0]         cam_rd_data_i
);

    logic [MAC_W-1:0]          req_mac;
    logic [VID_W-1:0]          req_vid;
    logic [1:0]                row_match;
    logic [1:0][PORT_W-1:0]    row_port;

    // One decoder per memory: index 0 is the bucket SRAM, index 1 the CAM
    for (genvar gi = 0; gi < 2; gi++) begin : g_dec
        logic [ENTRY_W-1:0] row;
        if (gi == 0) begin : g_sram
            assign row = sram_rd_data_i;
        end else begin : g_cam
            assign row = cam_rd_data_i;
        end
        l2_entry_decode i_dec (
            .row_i     (row),
            .req_mac_i (req_mac),
            .req_vid_i (req_vid),
            .match_o   (row_match[gi]),
            .port_o    (row_port[gi])
        );
    end

    l2_scan_ctrl #(
        .BUCKET_W  (BUCKET_W),
        .SLOTS     (SLOTS),
        .CAM_DEPTH (CAM_DEPTH),
        .SLOT_W    (SLOT_W),
        .CAM_W     (CAM_W),
        .IDX_W     (IDX_W)
    ) i_ctrl (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .start_i        (start_i),
        .mac_i          (mac_i),
        .vid_i          (vid_i),
        .bucket_i       (bucket_i),
        .req_mac_o      (req_mac),
        .req_vid_o      (req_vid),
        .match_i        (row_match),
        .port_i         (row_port),
        .sram_rd_en_o   (sram_rd_en_o),
        .sram_rd_addr_o (sram_rd_addr_o),
        .cam_rd_en_o    (cam_rd_en_o),
        .cam_rd_addr_o  (cam_rd_addr_o),
        .done_o         (done_o),
        .hit_o          (hit_o),
        .in_cam_o       (hit_in_cam_o),
        .idx_o          (hit_idx_o),
        .port_o         (hit_port_o)
    );

endmodule

// File: tb/test_l2_fwd_lookup.sv
`timescale 1ns/1ps
module test_l2_fwd_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] mac = '0;
    logic [11:0] vid = '0;
    logic [10:0] bucket = '0;
    logic        done, hit, in_cam, sram_en, cam_en;
    logic [5:0]  idx;
    logic [4:0]  port;
    logic [12:0] sram_addr;
    logic [5:0]  cam_addr;
    logic [95:0] sram_data = '0;
    logic [95:0] cam_data = '0;

    logic [95:0] slot_mem [0:3];
    logic [95:0] cam_mem  [0:63];
    logic [10:0] cur_bucket = 11'h000;

    int checks = 0;
    int failures = 0;
    int r_hit, r_cam, r_idx, r_port, r_lat;

    localparam logic [31:0] F_STATIC = 32'h0008_0000;

    always #2.5 clk = ~clk;

    l2_fwd_lookup i_l2_fwd_lookup (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mac_i(mac), .vid_i(vid),
        .bucket_i(bucket), .done_o(done), .hit_o(hit), .hit_in_cam_o(in_cam),
        .hit_idx_o(idx), .hit_port_o(port), .sram_rd_en_o(sram_en),
        .sram_rd_addr_o(sram_addr), .sram_rd_data_i(sram_data),
        .cam_rd_en_o(cam_en), .cam_rd_addr_o(cam_addr), .cam_rd_data_i(cam_data)
    );

    // Memory models: one-cycle registered reads; SRAM serves only the bucket under test
    always_ff @(posedge clk) begin
        if (sram_en) sram_data <= (sram_addr[12:2] == cur_bucket) ? slot_mem[sram_addr[1:0]] : '0;
        if (cam_en)  cam_data  <= cam_mem[cam_addr];
    end

    function automatic logic [95:0] mk_row(input logic [47:0] m, input logic [11:0] v,
                                           input logic [4:0] p, input logic [31:0] f0,
                                           input logic [31:0] f1);
        logic [31:0] w0, w1, w2;
        w0 = f0 | {15'd0, p, v};
        w1 = f1 | {4'd0, m[47:20]};
        w2 = {m[19:0], 12'h000};
        return {w2, w1, w0};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4; i++)  slot_mem[i] = '0;
        for (int i = 0; i < 64; i++) cam_mem[i]  = '0;
    endtask

    task automatic lookup(input logic [47:0] m, input logic [11:0] v, input logic [10:0] b,
                          input int inject_at, input logic [47:0] alt_mac);
        @(negedge clk);
        mac = m; vid = v; bucket = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        r_lat = 0;
        r_hit = -1;
        for (int n = 1; n <= 200; n++) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (n == inject_at) begin
                start = 1'b1; mac = alt_mac;
            end
            if (done) begin
                r_lat = n; r_hit = hit; r_cam = in_cam; r_idx = idx; r_port = port;
                break;
            end
        end
        start = 1'b0;
    endtask

    task automatic expect_res(input string req, input int h, input int c, input int i,
                              input int p, input int lat);
        check(req, "hit", r_hit, h);
        check(req, "in_cam", r_cam, c);
        check(req, "idx", r_idx, i);
        check(req, "port", r_port, p);
        check(req, "latency", r_lat, lat);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "done in reset", done, 0);
        check("R1", "hit in reset", hit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", done, 0);
        check("R1", "sram_en idle", sram_en, 0);
        check("R1", "cam_en idle", cam_en, 0);
    endtask

    task automatic t_slot_hit();
        clear_mem();
        cur_bucket = 11'h2C5;
        slot_mem[2] = mk_row(48'h0012_3456_789A, 12'h064, 5'd13, F_STATIC, 32'h0);
        lookup(48'h0012_3456_789A, 12'h064, 11'h2C5, 0, '0);
        expect_res("R2 R8 slot hit", 1, 0, 2, 13, 4);
        @(negedge clk);
        check("R10", "done pulse width", done, 0);
        repeat (3) @(negedge clk);
        check("R10", "hit held", hit, 1);
        check("R10", "port held", port, 13);
    endtask

    task automatic t_cam_hit();
        clear_mem();
        cam_mem[37] = mk_row(48'h02AA_BBCC_DDEE, 12'h005, 5'd21, F_STATIC, 32'h0);
        lookup(48'h02AA_BBCC_DDEE, 12'h005, 11'h2C5, 0, '0);
        expect_res("R2 R8 cam hit", 1, 1, 37, 21, 43);
        cam_mem[37] = '0;
        cam_mem[63] = mk_row(48'h02AA_BBCC_DDEE, 12'h005, 5'd31, F_STATIC, 32'h0);
        lookup(48'h02AA_BBCC_DDEE, 12'h005, 11'h2C5, 0, '0);
        expect_res("R2 R8 last cam entry", 1, 1, 63, 31, 69);
    endtask

    task automatic t_miss();
        clear_mem();
        lookup(48'h0000_0000_0001, 12'h001, 11'h2C5, 0, '0);
        expect_res("R9 empty miss", 0, 0, 0, 0, 69);
    endtask

    task automatic t_field_compare();
        clear_mem();
        slot_mem[0] = mk_row(48'h0010_2030_4051, 12'h123, 5'd1, F_STATIC, 32'h0);
        slot_mem[1] = mk_row(48'h0010_2030_4050, 12'h124, 5'd2, F_STATIC, 32'h0);
        slot_mem[2] = mk_row(48'h8010_2030_4050, 12'h123, 5'd3, F_STATIC, 32'h0);
        slot_mem[3] = mk_row(48'h0010_2030_4050, 12'h123, 5'd4, F_STATIC, 32'h0);
        lookup(48'h0010_2030_4050, 12'h123, 11'h2C5, 0, '0);
        expect_res("R3 mac/vid compare", 1, 0, 3, 4, 5);
    endtask

    task automatic t_occupancy();
        logic [31:0] f0s [0:5];
        logic [31:0] f1s [0:5];
        f0s = '{32'h0004_0000, 32'h0008_0000, 32'h0010_0000, 32'h0, 32'h0, 32'h0};
        f1s = '{32'h0, 32'h0, 32'h0, 32'h1000_0000, 32'h4000_0000, 32'h8000_0000};
        clear_mem();
        slot_mem[0] = mk_row(48'h0044_5566_7788, 12'h010, 5'd5, 32'h0, 32'h0);
        slot_mem[1] = mk_row(48'h0044_5566_7788, 12'h010, 5'd6, 32'h0002_0000, 32'h0);
        slot_mem[2] = mk_row(48'h0044_5566_7788, 12'h010, 5'd7, 32'h0, 32'h2000_0000);
        cam_mem[5]  = mk_row(48'h0044_5566_7788, 12'h010, 5'd8, 32'h0, 32'h1000_0000);
        lookup(48'h0044_5566_7788, 12'h010, 11'h2C5, 0, '0);
        expect_res("R4 empty rows skipped", 1, 1, 5, 8, 11);
        for (int k = 0; k < 6; k++) begin
            clear_mem();
            slot_mem[1] = mk_row(48'h0044_5566_7788, 12'h010, 5'(k + 9), f0s[k], f1s[k]);
            lookup(48'h0044_5566_7788, 12'h010, 11'h2C5, 0, '0);
            expect_res("R4 single flag occupies", 1, 0, 1, k + 9, 3);
        end
    endtask

    task automatic t_ip_group();
        clear_mem();
        slot_mem[0] = mk_row(48'h0066_7788_99AA, 12'h020, 5'd1, 32'h0040_0000, 32'h0);
        slot_mem[1] = mk_row(48'h0066_7788_99AA, 12'h020, 5'd2, 32'h0020_0000 | F_STATIC, 32'h0);
        cam_mem[0]  = mk_row(48'h0066_7788_99AA, 12'h020, 5'd3, F_STATIC, 32'h0);
        lookup(48'h0066_7788_99AA, 12'h020, 11'h2C5, 0, '0);
        expect_res("R5 ip group rows never match", 1, 1, 0, 3, 6);
    endtask

    task automatic t_eth_group();
        clear_mem();
        slot_mem[0] = mk_row(48'h0100_5E00_0001, 12'h030, 5'd4, F_STATIC, 32'h8000_0000);
        lookup(48'h0100_5E00_0001, 12'h030, 11'h2C5, 0, '0);
        expect_res("R6 group MAC never matches", 0, 0, 0, 0, 69);
    endtask

    task automatic t_priority();
        clear_mem();
        slot_mem[1] = mk_row(48'h0077_0000_0001, 12'h040, 5'd7, F_STATIC, 32'h0);
        slot_mem[3] = mk_row(48'h0077_0000_0001, 12'h040, 5'd9, F_STATIC, 32'h0);
        cam_mem[0]  = mk_row(48'h0077_0000_0001, 12'h040, 5'd11, F_STATIC, 32'h0);
        lookup(48'h0077_0000_0001, 12'h040, 11'h2C5, 0, '0);
        expect_res("R7 first slot wins", 1, 0, 1, 7, 3);
        slot_mem[1] = '0;
        slot_mem[3] = '0;
        cam_mem[0]  = '0;
        cam_mem[10] = mk_row(48'h0077_0000_0001, 12'h040, 5'd12, F_STATIC, 32'h0);
        cam_mem[20] = mk_row(48'h0077_0000_0001, 12'h040, 5'd14, F_STATIC, 32'h0);
        lookup(48'h0077_0000_0001, 12'h040, 11'h2C5, 0, '0);
        expect_res("R7 lowest cam index wins", 1, 1, 10, 12, 16);
    endtask

    task automatic t_bucket_addr();
        clear_mem();
        cur_bucket = 11'h5A3;
        slot_mem[0] = mk_row(48'h0088_0000_0002, 12'h050, 5'd15, F_STATIC, 32'h0);
        lookup(48'h0088_0000_0002, 12'h050, 11'h5A3, 0, '0);
        expect_res("R2 bucket addressed", 1, 0, 0, 15, 2);
        lookup(48'h0088_0000_0002, 12'h050, 11'h1A3, 0, '0);
        expect_res("R2 other bucket misses", 0, 0, 0, 0, 69);
    endtask

    task automatic t_busy_start();
        clear_mem();
        cam_mem[30] = mk_row(48'h0099_0000_0003, 12'h060, 5'd17, F_STATIC, 32'h0);
        slot_mem[0] = mk_row(48'h0099_0000_0004, 12'h060, 5'd18, F_STATIC, 32'h0);
        lookup(48'h0099_0000_0003, 12'h060, 11'h5A3, 3, 48'h0099_0000_0004);
        expect_res("R11 start ignored while busy", 1, 1, 30, 17, 36);
        @(negedge clk);
        check("R11", "no second scan", done, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(posedge clk);
        t_reset();
        t_slot_hit();
        t_cam_hit();
        t_miss();
        t_field_compare();
        t_occupancy();
        t_ip_group();
        t_eth_group();
        t_priority();
        t_bucket_addr();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule